// File: doc/BRIEF.md
# Software Trap Vector and Trap Return Resolver

This block does two jobs for a small processor's trap logic. For a software trap instruction it adds a base operand to an offset operand and turns the sum into a trap vector number. The number always has its top bit set, so every software trap maps into the upper half of an 8-bit vector space. For the return-from-trap instruction it looks at the privilege, previous-privilege and trap-enable bits of the status word, at the core's debug-mode flag and at the debug-select bit of the instruction. From these it picks the next PC and the new status bits, and it may raise a halt request, an illegal-instruction request or a strobe that ends debug mode.

Each request is a one-cycle strobe. The matching result appears on registered outputs on the following cycle, qualified by its own valid pulse. The PC redirect, the status write and any strobes come out together in that cycle. The two paths are independent, so a trap request and a return request may arrive in the same cycle.

Top module: `trap_ctl`

## Requirements
- R1: The trap number equals 0x80 plus the low 7 bits of the sum of the base and offset operands, with the sum taken modulo the operand width. It therefore always lies in 0x80..0xFF.
- R2: `trap_vld` pulses high for exactly one cycle, in the cycle after `trap_req` is sampled high. `trap_num` carries the result in that cycle.
- R3: `ret_vld` pulses high in the cycle after `ret_req` is sampled high. `halt_req`, `ill_req`, `psr_wr` and `dbg_clr` are high only in a cycle where `ret_vld` is high.
- R4: A return with privilege bit S=0 and enable bit ET=0 raises `halt_req`. `nxt_pc` is PC+4 and `psr_wr` stays 0, whatever the debug inputs are.
- R5: A return with S=0 and ET=1 gives `nxt_pc` = PC+4, with no halt, no illegal request and no status write, whatever the debug inputs are.
- R6: A return with S=1 and ET=1 raises `ill_req` and gives `nxt_pc` = PC+4 with no status write. This check comes after the S=0 check and before any restore.
- R7: A return with S=1, ET=0, debug mode 0 and debug-select 0 takes `nxt_pc` from the normal saved PC. It sets `psr_wr`, drives `new_et`=1 and drives `new_s` from the previous-privilege bit.
- R8: A return with S=1, ET=0, debug mode 1 and debug-select 1 takes `nxt_pc` from the debug saved PC. It sets `psr_wr`, drives `new_et` and `new_s` from the saved debug bits, and pulses `dbg_clr`.
- R9: A return with S=1, ET=0 and the debug mode not equal to the debug-select bit gives `nxt_pc` = PC+4 with no strobe and no status write.
- R10: Whenever `psr_wr` is 0 in a valid return, `new_s` and `new_et` repeat the S and ET values sampled with the request.
- R11: While the synchronous active-high reset is held, `trap_vld`, `ret_vld`, `halt_req`, `ill_req`, `psr_wr` and `dbg_clr` are 0 in the following cycle, even when requests are present.
- R12: PC+4 wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Software trap strobe |
| trap_base | input | OPD_W | Trap base operand |
| trap_ofs | input | OPD_W | Trap offset operand |
| ret_req | input | 1 | Return-from-trap strobe |
| cur_pc | input | PC_W | PC of the return instruction |
| psr_s | input | 1 | Current privilege bit |
| psr_ps | input | 1 | Previous privilege bit |
| psr_et | input | 1 | Trap-enable bit |
| dbg_mode | input | 1 | Core is in debug mode |
| dbg_sel | input | 1 | Debug-select bit of the return instruction |
| sav_pc | input | PC_W | Saved PC for a normal return |
| sav_dbg_pc | input | PC_W | Saved PC for a debug return |
| sav_dbg_et | input | 1 | Saved trap-enable for a debug return |
| sav_dbg_s | input | 1 | Saved privilege for a debug return |
| trap_vld | output | 1 | Trap number valid |
| trap_num | output | VEC_BITS+1 | Trap vector number |
| ret_vld | output | 1 | Return result valid |
| nxt_pc | output | PC_W | Next PC |
| new_s | output | 1 | Privilege bit after return |
| new_et | output | 1 | Trap-enable bit after return |
| psr_wr | output | 1 | Status word is written |
| dbg_clr | output | 1 | Leave debug mode |
| halt_req | output | 1 | Halt request |
| ill_req | output | 1 | Illegal-instruction request |

## Verification
The bound checker watches on every cycle the one-cycle timing of both result pulses. It also checks that the strobes only appear with a valid return and that halt and illegal never appear together. It checks that a return without a status write steps the PC by four and echoes the sampled status bits, and that the trap number matches the sampled operands. The ordering of the decision chain shows only in the bench's scenarios. These include a user-mode return with both debug inputs set, an enabled-trap return with a matching debug pair, and the two mismatched debug pairs. The bench's scenarios also show the exact restore sources, the operand wrap cases and the PC wrap at the top of the address space.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

   typedef enum logic [2:0] {
      RK_USER_HALT = 3'd0,
      RK_USER      = 3'd1,
      RK_ILLEGAL   = 3'd2,
      RK_NORMAL    = 3'd3,
      RK_DEBUG     = 3'd4,
      RK_STEP      = 3'd5
   } ret_kind_e;

   typedef struct packed {
      logic halt;
      logic ill;
      logic psr_wr;
      logic dbg_clr;
      logic s;
      logic et;
   } ret_flags_t;

endpackage

// File: rtl/trap_ctl_vec.sv
module trap_ctl_vec #(
   parameter int OPD_W    = 32,
   parameter int VEC_BITS = 7
) (
   input  logic [OPD_W-1:0]  base,
   input  logic [OPD_W-1:0]  ofs,
   output logic [VEC_BITS:0] num
);
   logic [VEC_BITS-1:0] low_sum;

   if (VEC_BITS < 1) begin : g_bad_vec
      $error("trap_ctl_vec: VEC_BITS must be at least 1");
   end

   if (OPD_W > VEC_BITS) begin : g_wide
      logic [OPD_W-1:0] full_sum;
      logic             unused_hi;
      assign full_sum  = base + ofs;
      assign low_sum   = full_sum[VEC_BITS-1:0];
      assign unused_hi = ^full_sum[OPD_W-1:VEC_BITS];
   end else begin : g_narrow
      logic [VEC_BITS-1:0] b_ext;
      logic [VEC_BITS-1:0] o_ext;
      assign b_ext   = VEC_BITS'(base);
      assign o_ext   = VEC_BITS'(ofs);
      assign low_sum = (OPD_W == VEC_BITS) ? (b_ext + o_ext)
                                           : ((b_ext + o_ext) & VEC_BITS'((1 << OPD_W) - 1));
   end

   assign num = {1'b1, low_sum};
endmodule

// File: rtl/trap_ctl_ret_sel.sv
module trap_ctl_ret_sel
   import trap_ctl_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic [PC_W-1:0] pc,
   input  logic            s,
   input  logic            ps,
   input  logic            et,
   input  logic            dbg_mode,
   input  logic            dbg_sel,
   input  logic [PC_W-1:0] sav_pc,
   input  logic [PC_W-1:0] sav_dbg_pc,
   input  logic            sav_dbg_et,
   input  logic            sav_dbg_s,
   output ret_kind_e       kind,
   output logic [PC_W-1:0] npc,
   output ret_flags_t      flags
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

   logic [PC_W-1:0] seq_pc;
   assign seq_pc = pc + STEP;

   // strict order: privilege, enable, normal restore, debug restore
   always_comb begin
      if (!s)
         kind = et ? RK_USER : RK_USER_HALT;
      else if (et)
         kind = RK_ILLEGAL;
      else if (!dbg_mode && !dbg_sel)
         kind = RK_NORMAL;
      else if (dbg_mode && dbg_sel)
         kind = RK_DEBUG;
      else
         kind = RK_STEP;
   end

   always_comb begin
      flags = '{halt: 1'b0, ill: 1'b0, psr_wr: 1'b0, dbg_clr: 1'b0, s: s, et: et};
      npc   = seq_pc;
      unique case (kind)
         RK_USER_HALT: flags.halt = 1'b1;
         RK_ILLEGAL:   flags.ill  = 1'b1;
         RK_NORMAL: begin
            npc          = sav_pc;
            flags.psr_wr = 1'b1;
            flags.et     = 1'b1;
            flags.s      = ps;
         end
         RK_DEBUG: begin
            npc           = sav_dbg_pc;
            flags.psr_wr  = 1'b1;
            flags.dbg_clr = 1'b1;
            flags.et      = sav_dbg_et;
            flags.s       = sav_dbg_s;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/trap_ctl.sv
module trap_ctl
   import trap_ctl_pkg::*;
#(
   parameter int OPD_W      = 32,
   parameter int PC_W       = 32,
   parameter int VEC_BITS   = 7,
   parameter int INSN_BYTES = 4
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                trap_req,
   input  logic [OPD_W-1:0]    trap_base,
   input  logic [OPD_W-1:0]    trap_ofs,
   input  logic                ret_req,
   input  logic [PC_W-1:0]     cur_pc,
   input  logic                psr_s,
   input  logic                psr_ps,
   input  logic                psr_et,
   input  logic                dbg_mode,
   input  logic                dbg_sel,
   input  logic [PC_W-1:0]     sav_pc,
   input  logic [PC_W-1:0]     sav_dbg_pc,
   input  logic                sav_dbg_et,
   input  logic                sav_dbg_s,
   output logic                trap_vld,
   output logic [VEC_BITS:0]   trap_num,
   output logic                ret_vld,
   output logic [PC_W-1:0]     nxt_pc,
   output logic                new_s,
   output logic                new_et,
   output logic                psr_wr,
   output logic                dbg_clr,
   output logic                halt_req,
   output logic                ill_req
);
   if (PC_W < 3) begin : g_bad_pc
      $error("trap_ctl: PC_W must be at least 3");
   end
   if (INSN_BYTES < 1) begin : g_bad_step
      $error("trap_ctl: INSN_BYTES must be positive");
   end

   logic [VEC_BITS:0] vec_d;
   ret_kind_e         kind_d;
   logic [PC_W-1:0]   npc_d;
   ret_flags_t        flg_d;
   ret_flags_t        flg_q;

   trap_ctl_vec #(.OPD_W(OPD_W), .VEC_BITS(VEC_BITS)) u_vec (
      .base (trap_base),
      .ofs  (trap_ofs),
      .num  (vec_d)
   );

   trap_ctl_ret_sel #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_sel (
      .pc         (cur_pc),
      .s          (psr_s),
      .ps         (psr_ps),
      .et         (psr_et),
      .dbg_mode   (dbg_mode),
      .dbg_sel    (dbg_sel),
      .sav_pc     (sav_pc),
      .sav_dbg_pc (sav_dbg_pc),
      .sav_dbg_et (sav_dbg_et),
      .sav_dbg_s  (sav_dbg_s),
      .kind       (kind_d),
      .npc        (npc_d),
      .flags      (flg_d)
   );

   logic unused_kind;
   assign unused_kind = ^kind_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         trap_vld <= 1'b0;
         trap_num <= '0;
      end else begin
         trap_vld <= trap_req;
         if (trap_req) trap_num <= vec_d;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ret_vld <= 1'b0;
         nxt_pc  <= '0;
         flg_q   <= '0;
      end else begin
         ret_vld <= ret_req;
         if (ret_req) begin
            nxt_pc <= npc_d;
            flg_q  <= flg_d;
         end else begin
            flg_q.halt    <= 1'b0;
            flg_q.ill     <= 1'b0;
            flg_q.psr_wr  <= 1'b0;
            flg_q.dbg_clr <= 1'b0;
         end
      end
   end

   assign new_s    = flg_q.s;
   assign new_et   = flg_q.et;
   assign psr_wr   = flg_q.psr_wr;
   assign dbg_clr  = flg_q.dbg_clr;
   assign halt_req = flg_q.halt;
   assign ill_req  = flg_q.ill;
endmodule

// File: rtl/trap_ctl_chk.sv
module trap_ctl_chk #(
   parameter int OPD_W      = 32,
   parameter int PC_W       = 32,
   parameter int VEC_BITS   = 7,
   parameter int INSN_BYTES = 4
) (
   input logic                clk,
   input logic                rst,
   input logic                trap_req,
   input logic [OPD_W-1:0]    trap_base,
   input logic [OPD_W-1:0]    trap_ofs,
   input logic                ret_req,
   input logic [PC_W-1:0]     cur_pc,
   input logic                psr_s,
   input logic                psr_et,
   input logic                trap_vld,
   input logic [VEC_BITS:0]   trap_num,
   input logic                ret_vld,
   input logic [PC_W-1:0]     nxt_pc,
   input logic                new_s,
   input logic                new_et,
   input logic                psr_wr,
   input logic                dbg_clr,
   input logic                halt_req,
   input logic                ill_req
);
   localparam logic [OPD_W-1:0] LOW_MASK = OPD_W'((1 << VEC_BITS) - 1);

   AST_TRAP_RANGE: assert property (@(posedge clk) disable iff (rst)
      trap_req |=> (trap_num[VEC_BITS] &&
                    OPD_W'(trap_num[VEC_BITS-1:0]) ==
                    (($past(trap_base) + $past(trap_ofs)) & LOW_MASK))); // R1

   AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (rst)
      trap_req |=> trap_vld);                                            // R2

   AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (rst)
      !trap_req |=> !trap_vld);                                          // R2

   AST_RET_PULSE: assert property (@(posedge clk) disable iff (rst)
      ret_req |=> ret_vld);                                              // R3

   AST_STROBE_QUAL: assert property (@(posedge clk) disable iff (rst)
      (halt_req || ill_req || psr_wr || dbg_clr) |-> ret_vld);           // R3

   AST_HALT_USER: assert property (@(posedge clk) disable iff (rst)
      ret_req |=> (halt_req == (!$past(psr_s) && !$past(psr_et))));      // R4

   AST_ILL_ENABLED: assert property (@(posedge clk) disable iff (rst)
      ret_req |=> (ill_req == ($past(psr_s) && $past(psr_et))));         // R6

   AST_HALT_ILL_EXCL: assert property (@(posedge clk) disable iff (rst)
      $countones({halt_req, ill_req, psr_wr}) <= 1);                     // R6

   AST_DBG_CLR_WR: assert property (@(posedge clk) disable iff (rst)
      dbg_clr |-> psr_wr);                                               // R8

   AST_STEP_PC: assert property (@(posedge clk) disable iff (rst)
      (ret_req ##1 !psr_wr) |-> nxt_pc == $past(cur_pc) + PC_W'(INSN_BYTES)); // R12

   AST_ECHO_PSR: assert property (@(posedge clk) disable iff (rst)
      (ret_req ##1 !psr_wr) |-> (new_s == $past(psr_s) && new_et == $past(psr_et))); // R10
endmodule

bind trap_ctl trap_ctl_chk #(
   .OPD_W(OPD_W), .PC_W(PC_W), .VEC_BITS(VEC_BITS), .INSN_BYTES(INSN_BYTES)
) u_trap_ctl_chk (.*);

// File: tb/test_trap_ctl.sv
`timescale 1ns/1ps
module test_trap_ctl;
   localparam int OPD_W = 32;
   localparam int PC_W  = 32;

   typedef struct {
      bit          rst;
      bit          tv;
      logic [7:0]  tn;
      bit          rv;
      logic [31:0] pc;
      bit          s, et, wr, dc, hl, il;
      string       tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic trap_req = 0, ret_req = 0;
   logic [31:0] trap_base = 0, trap_ofs = 0, cur_pc = 0, sav_pc = 0, sav_dbg_pc = 0;
   logic psr_s = 0, psr_ps = 0, psr_et = 0, dbg_mode = 0, dbg_sel = 0;
   logic sav_dbg_et = 0, sav_dbg_s = 0;
   logic trap_vld, ret_vld, new_s, new_et, psr_wr, dbg_clr, halt_req, ill_req;
   logic [7:0]  trap_num;
   logic [31:0] nxt_pc;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   trap_ctl i_trap_ctl (
      .clk(clk), .rst(rst), .trap_req(trap_req), .trap_base(trap_base),
      .trap_ofs(trap_ofs), .ret_req(ret_req), .cur_pc(cur_pc), .psr_s(psr_s),
      .psr_ps(psr_ps), .psr_et(psr_et), .dbg_mode(dbg_mode), .dbg_sel(dbg_sel),
      .sav_pc(sav_pc), .sav_dbg_pc(sav_dbg_pc), .sav_dbg_et(sav_dbg_et),
      .sav_dbg_s(sav_dbg_s), .trap_vld(trap_vld), .trap_num(trap_num),
      .ret_vld(ret_vld), .nxt_pc(nxt_pc), .new_s(new_s), .new_et(new_et),
      .psr_wr(psr_wr), .dbg_clr(dbg_clr), .halt_req(halt_req), .ill_req(ill_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: expectation from the inputs driven this cycle
   task automatic predict(input string tag_ovr);
      exp_t e;
      logic [31:0] sum;
      e.rst = rst; e.tv = 0; e.tn = 0; e.rv = 0; e.pc = 0;
      e.s = 0; e.et = 0; e.wr = 0; e.dc = 0; e.hl = 0; e.il = 0; e.tag = "R3";
      if (!rst) begin
         e.tv  = trap_req;
         sum   = trap_base + trap_ofs;
         e.tn  = 8'h80 + {1'b0, sum[6:0]};
         e.rv  = ret_req;
         if (ret_req) begin
            e.pc = cur_pc + 32'd4;
            e.s  = psr_s;
            e.et = psr_et;
            if (!psr_s && !psr_et) begin e.hl = 1; e.tag = "R4"; end
            else if (!psr_s) e.tag = "R5";
            else if (psr_et) begin e.il = 1; e.tag = "R6"; end
            else if (!dbg_mode && !dbg_sel) begin
               e.pc = sav_pc; e.wr = 1; e.et = 1; e.s = psr_ps; e.tag = "R7";
            end else if (dbg_mode && dbg_sel) begin
               e.pc = sav_dbg_pc; e.wr = 1; e.dc = 1;
               e.et = sav_dbg_et; e.s = sav_dbg_s; e.tag = "R8";
            end else e.tag = "R9";
         end
      end
      if (tag_ovr != "") e.tag = tag_ovr;
      q.push_back(e);
   endtask

   task automatic compare();
      exp_t e;
      if (q.size() == 0) return;
      e = q.pop_front();
      if (e.rst) begin
         chk("R11 trap_vld", {31'd0, trap_vld}, 0);
         chk("R11 ret_vld",  {31'd0, ret_vld}, 0);
         chk("R11 strobes",  {28'd0, halt_req, ill_req, psr_wr, dbg_clr}, 0);
         return;
      end
      chk("R2 trap_vld", {31'd0, trap_vld}, {31'd0, e.tv});
      if (e.tv) chk("R1 trap_num", {24'd0, trap_num}, {24'd0, e.tn});
      chk("R3 ret_vld", {31'd0, ret_vld}, {31'd0, e.rv});
      chk({e.tag, " halt_req"}, {31'd0, halt_req}, {31'd0, e.hl});
      chk({e.tag, " ill_req"},  {31'd0, ill_req},  {31'd0, e.il});
      chk({e.tag, " psr_wr"},   {31'd0, psr_wr},   {31'd0, e.wr});
      chk({e.tag, " dbg_clr"},  {31'd0, dbg_clr},  {31'd0, e.dc});
      if (e.rv) begin
         chk({e.tag, " nxt_pc"}, nxt_pc, e.pc);
         chk({e.tag, (e.wr ? "" : " R10"), " new_s/et"},
             {30'd0, new_s, new_et}, {30'd0, e.s, e.et});
      end
   endtask

   task automatic idle();
      trap_req = 0; ret_req = 0;
   endtask

   task automatic ret(input logic s, ps, et, dm, ds, input logic [31:0] pc);
      ret_req = 1; psr_s = s; psr_ps = ps; psr_et = et;
      dbg_mode = dm; dbg_sel = ds; cur_pc = pc;
   endtask

   task automatic cyc(input string tag_ovr);
      predict(tag_ovr);
      @(negedge clk);
      compare();
   endtask

   initial begin
      @(negedge clk);
      // R11: requests held during reset must not produce results
      rst = 1; trap_req = 1; ret_req = 1; psr_s = 0; psr_et = 0;
      cyc("");
      cyc("");
      rst = 0; idle();
      cyc("");
      sav_pc = 32'h0000_4000; sav_dbg_pc = 32'h0000_8800;
      sav_dbg_et = 1; sav_dbg_s = 0;
      // R7 normal restore, PS=0 and PS=1
      ret(1, 0, 0, 0, 0, 32'h100); cyc("R7");
      ret(1, 1, 0, 0, 0, 32'h104); cyc("R7");
      // R8 debug restore, both saved-bit patterns
      ret(1, 1, 0, 1, 1, 32'h200); cyc("R8");
      sav_dbg_et = 0; sav_dbg_s = 1;
      ret(1, 0, 0, 1, 1, 32'h204); cyc("R8");
      // R9 mismatched debug pairs
      ret(1, 1, 0, 1, 0, 32'h300); cyc("R9");
      ret(1, 1, 0, 0, 1, 32'h304); cyc("R9");
      // R4/R5 user mode overrides matching debug pairs
      ret(0, 1, 0, 1, 1, 32'h400); cyc("R4");
      ret(0, 1, 1, 0, 0, 32'h404); cyc("R5");
      // R6 enabled traps outrank a debug restore
      ret(1, 1, 1, 1, 1, 32'h500); cyc("R6");
      // R12 PC wrap
      ret(1, 0, 1, 0, 1, 32'hFFFF_FFFE); cyc("R12");
      ret(0, 0, 0, 0, 0, 32'hFFFF_FFFC); cyc("R12");
      idle(); cyc("");
      // R1 operand corner cases
      trap_req = 1; trap_base = 32'h7F; trap_ofs = 32'h1;        cyc("");
      trap_base = 32'hFFFF_FFFF; trap_ofs = 32'h0;               cyc("");
      trap_base = 32'h5; trap_ofs = 32'hFFFF_FFFD;               cyc("");
      trap_base = 32'h0; trap_ofs = 32'h0;                       cyc("");
      // R2 back-to-back and single request with a return in parallel
      ret(1, 1, 0, 0, 0, 32'h600); trap_base = 32'h1234; cyc("");
      idle(); cyc("");
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         trap_req   = $urandom_range(0, 1);
         trap_base  = $urandom; trap_ofs = $urandom;
         ret_req    = $urandom_range(0, 1);
         cur_pc     = $urandom; sav_pc = $urandom; sav_dbg_pc = $urandom;
         {psr_s, psr_ps, psr_et, dbg_mode, dbg_sel, sav_dbg_et, sav_dbg_s} = 7'($urandom);
         rst = ($urandom_range(0, 99) == 0);
         cyc("");
      end
      rst = 0; idle();
      cyc("");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule